// File: doc/BRIEF.md
# Serial Command Core for a 10-bit Digital Potentiometer

This block is the logic side of a digitally set resistor with 1024 taps. A host shifts 16-bit command words in over a three-wire serial port: a clock, a data line and an active-low frame strobe. The block decodes each word and acts on three kinds of state:

- a 10-bit wiper code;
- a 3-bit control register;
- a model of a 20-slot one-time-programmable store that remembers wiper codes.

Its outputs are the wiper code, a shutdown flag and a resistor-performance enable. All of these drive the analog ladder, which lies outside this block.

The serial pins are sampled by the system clock through synchronisers, and the serial clock is much slower than the system clock. The serial port is a plain pin interface with no valid/ready pair and no back-pressure. The host owns the pace of the serial clock, and a frame is acted on only when the strobe returns high. The serial output shows the most significant bit of the internal shift register. It therefore serves two uses. It returns readback words during the next frame, and it forwards the bit stream so that several devices can be chained and share one strobe.

Each word is laid out, most significant bit first, as follows:

| Bits | Content |
|------|---------|
| 15:14 | don't care |
| 13:10 | command |
| 9:0 | data |

Top module: `dpot_core`

## Requirements
- R1: Bits are sampled on falling serial-clock edges while `sync_n` is low. When `sync_n` rises after a nonzero multiple of 16 bits, the last 16 bits received execute as one command.
- R2: If `sync_n` rises after a bit count that is not a multiple of 16, the frame is dropped and no state changes.
- R3: Command 6 loads the control register from data bits 2:0: bit 0 enables programming, bit 1 enables wiper writes, and bit 2 drives `perf_en`. Command 1 loads the wiper from data bits 9:0 only while control bit 1 is set; otherwise it is ignored.
- R4: Command 8 sets `shutdown` to data bit 0. Shutdown leaves the wiper code unchanged, and every command is still accepted and executed while shut down.
- R5: A software reset (command 4) or a rising edge on `hw_reset` reloads the wiper with the most recently programmed slot, or with midscale (512) if no slot holds a value. Both also return the control register to all zeros.
- R6: Command 3 stores the current wiper code into the next free slot, but only while control bit 0 is set. Once all 20 slots are used, further programming is refused and the stored values are kept.
- R7: Command 2 (wiper) and command 5 (slot selected by data bits 4:0) place the 16-bit word {6 zero bits, 10-bit value} in the shift register. That word appears on `sdo`, most significant bit first, during the next frame. Reading a slot that was never programmed returns zero.
- R8: During a frame, `sdo` shows the bit shifted in 16 serial clocks earlier, so a chained device receives the leading 16 bits of a 32-bit stream.
- R9: After `rst_n`, the outputs are `wiper` = 512, `shutdown` = 0 and `perf_en` = 0, and no slot is programmed.
- R10: Command codes 0, 7 and 9 to 15 have no effect on any state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| sclk | input | 1 | Serial clock; data is taken on its falling edge |
| din | input | 1 | Serial data in |
| sync_n | input | 1 | Active-low frame strobe; its rising edge executes the frame |
| hw_reset | input | 1 | Reset pin; a rising edge reloads the wiper |
| sdo | output | 1 | Serial data out, used for readback and chaining |
| wiper | output | 10 | Current wiper code |
| shutdown | output | 1 | Shutdown flag |
| perf_en | output | 1 | Resistor-performance enable |

## Verification
The hardest state to reach from the pins is a full programmable store. Reaching it takes twenty separate program frames, each preceded by a wiper write. Only then can one more program attempt test the refusal and a reset test the reload from the last slot. The bench gets there with a loop that writes a distinct code and then programs it, nineteen more times after the first slot is used. It then proves the refusal two ways. A software reset must return the code stored twentieth, and a readback of the last slot must return that same code.

// File: rtl/dpot_pkg.sv
package dpot_pkg;

  typedef enum logic [3:0] {
    OP_NOP      = 4'd0,
    OP_WR_WIPER = 4'd1,
    OP_RD_WIPER = 4'd2,
    OP_PROG     = 4'd3,
    OP_SW_RST   = 4'd4,
    OP_RD_SLOT  = 4'd5,
    OP_WR_CTRL  = 4'd6,
    OP_SHDN     = 4'd8
  } op_e;

  typedef struct packed {
    logic perf;
    logic wr_en;
    logic prog_en;
  } ctrl_t;

endpackage

// File: rtl/dpot_serial_rx.sv
module dpot_serial_rx #(
  parameter int FRAME_W     = 16,
  parameter int PAYLOAD_W   = 14,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sclk,
  input  logic                 din,
  input  logic                 sync_n,
  input  logic                 load,
  input  logic [FRAME_W-1:0]   load_word,
  output logic                 sdo,
  output logic                 fire,
  output logic [PAYLOAD_W-1:0] payload
);
  localparam int CNT_W = $clog2(FRAME_W);

  logic [SYNC_STAGES:0]   sclk_s;
  logic [SYNC_STAGES:0]   sync_s;
  logic [SYNC_STAGES-1:0] din_s;
  logic [FRAME_W-1:0]     sr;
  logic [CNT_W-1:0]       cnt;
  logic                   have_bits;

  logic sclk_fall, sync_rise, sync_fall, sync_low, din_b;

  // synchronisers with one extra stage for edge detection
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_s <= '0;
      sync_s <= '1;
      din_s  <= '0;
    end else begin
      sclk_s <= {sclk_s[SYNC_STAGES-1:0], sclk};
      sync_s <= {sync_s[SYNC_STAGES-1:0], sync_n};
      din_s  <= {din_s[SYNC_STAGES-2:0], din};
    end
  end

  assign sclk_fall = sclk_s[SYNC_STAGES] & ~sclk_s[SYNC_STAGES-1];
  assign sync_rise = ~sync_s[SYNC_STAGES] & sync_s[SYNC_STAGES-1];
  assign sync_fall = sync_s[SYNC_STAGES] & ~sync_s[SYNC_STAGES-1];
  assign sync_low  = ~sync_s[SYNC_STAGES-1];
  assign din_b     = din_s[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr        <= '0;
      cnt       <= '0;
      have_bits <= 1'b0;
      fire      <= 1'b0;
    end else begin
      fire <= 1'b0;
      if (sync_fall) begin
        cnt       <= '0;
        have_bits <= 1'b0;
      end else if (sclk_fall && sync_low) begin
        sr        <= {sr[FRAME_W-2:0], din_b};
        cnt       <= (cnt == CNT_W'(FRAME_W-1)) ? '0 : cnt + CNT_W'(1);
        have_bits <= 1'b1;
      end else if (sync_rise) begin
        fire      <= have_bits && (cnt == '0);
        have_bits <= 1'b0;
      end else if (load) begin
        sr <= load_word;
      end
    end
  end

  assign sdo     = sr[FRAME_W-1];
  assign payload = sr[PAYLOAD_W-1:0];

endmodule

// File: rtl/dpot_otp.sv
module dpot_otp #(
  parameter int SLOTS  = 20,
  parameter int DATA_W = 10,
  parameter int IDX_W  = $clog2(SLOTS),
  parameter int USED_W = $clog2(SLOTS+1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prog,
  input  logic [DATA_W-1:0] prog_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] last_data,
  output logic              any,
  output logic [USED_W-1:0] used
);
  logic [DATA_W-1:0] mem [SLOTS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      used <= '0;
      for (int i = 0; i < SLOTS; i++) mem[i] <= '0;
    end else if (prog && (used < USED_W'(SLOTS))) begin
      used <= used + USED_W'(1);
      for (int i = 0; i < SLOTS; i++)
        if (used == USED_W'(i)) mem[i] <= prog_data;
    end
  end

  always_comb begin
    rd_data   = '0;
    last_data = '0;
    for (int i = 0; i < SLOTS; i++) begin
      if (rd_idx == IDX_W'(i))   rd_data   = mem[i];
      if (used == USED_W'(i+1))  last_data = mem[i];
    end
  end

  assign any = (used != '0);

endmodule

// File: rtl/dpot_core.sv
module dpot_core #(
  parameter int DATA_W      = 10,
  parameter int CMD_W       = 4,
  parameter int PAD_W       = 2,
  parameter int SLOTS       = 20,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              din,
  input  logic              sync_n,
  input  logic              hw_reset,
  output logic              sdo,
  output logic [DATA_W-1:0] wiper,
  output logic              shutdown,
  output logic              perf_en
);
  import dpot_pkg::*;

  localparam int FRAME_W   = PAD_W + CMD_W + DATA_W;
  localparam int PAYLOAD_W = CMD_W + DATA_W;
  localparam int IDX_W     = $clog2(SLOTS);
  localparam int USED_W    = $clog2(SLOTS+1);
  localparam logic [DATA_W-1:0] MID = DATA_W'(1) << (DATA_W-1);

  logic                 fire, load, prog, reload, otp_any;
  logic [PAYLOAD_W-1:0] payload;
  logic [FRAME_W-1:0]   load_word;
  logic [DATA_W-1:0]    data, slot_rd, slot_last, reload_val;
  logic [USED_W-1:0]    otp_used;
  logic [SYNC_STAGES:0] hw_s;
  logic                 hw_rise;
  ctrl_t                ctrl;
  op_e                  op;

  assign data = payload[DATA_W-1:0];
  assign op   = op_e'(payload[PAYLOAD_W-1 -: CMD_W]);

  dpot_serial_rx #(
    .FRAME_W(FRAME_W), .PAYLOAD_W(PAYLOAD_W), .SYNC_STAGES(SYNC_STAGES)
  ) u_rx (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .din(din), .sync_n(sync_n),
    .load(load), .load_word(load_word), .sdo(sdo), .fire(fire),
    .payload(payload)
  );

  dpot_otp #(
    .SLOTS(SLOTS), .DATA_W(DATA_W), .IDX_W(IDX_W), .USED_W(USED_W)
  ) u_otp (
    .clk(clk), .rst_n(rst_n), .prog(prog), .prog_data(wiper),
    .rd_idx(data[IDX_W-1:0]), .rd_data(slot_rd), .last_data(slot_last),
    .any(otp_any), .used(otp_used)
  );

  // reset pin synchroniser and rising-edge detect
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hw_s <= '0;
    else        hw_s <= {hw_s[SYNC_STAGES-1:0], hw_reset};
  end
  assign hw_rise = ~hw_s[SYNC_STAGES] & hw_s[SYNC_STAGES-1];

  assign reload     = hw_rise | (fire && op == OP_SW_RST);
  assign reload_val = otp_any ? slot_last : MID;
  assign prog       = fire && op == OP_PROG && ctrl.prog_en;
  assign load       = fire && (op == OP_RD_WIPER || op == OP_RD_SLOT);
  assign load_word  = {{(FRAME_W-DATA_W){1'b0}},
                       (op == OP_RD_WIPER) ? wiper : slot_rd};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wiper    <= MID;
      ctrl     <= '0;
      shutdown <= 1'b0;
    end else if (reload) begin
      wiper <= reload_val;
      ctrl  <= '0;
    end else if (fire) begin
      case (op)
        OP_WR_WIPER: if (ctrl.wr_en) wiper <= data;
        OP_WR_CTRL:  ctrl     <= ctrl_t'(data[2:0]);
        OP_SHDN:     shutdown <= data[0];
        default:     ;
      endcase
    end
  end

  assign perf_en = ctrl.perf;

endmodule

// File: rtl/dpot_core_chk.sv
module dpot_core_chk #(
  parameter int DATA_W = 10,
  parameter int SLOTS  = 20,
  parameter int USED_W = $clog2(SLOTS+1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [DATA_W-1:0] wiper,
  input logic              shutdown,
  input logic              perf_en,
  input logic              fire,
  input logic              hw_rise,
  input logic [USED_W-1:0] used
);
  a_r4_shdn_keeps_wiper: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(shutdown) |-> $stable(wiper));

  a_r1_shdn_moves_on_frame: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(shutdown) |-> $past(fire));

  a_r3_wiper_moves_on_event: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(wiper) |-> $past(fire || hw_rise));

  a_r3_perf_moves_on_event: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(perf_en) |-> $past(fire || hw_rise));

  a_r5_pin_reset_clears_perf: assert property (@(posedge clk) disable iff (!rst_n)
    hw_rise |=> !perf_en);

  a_r6_slots_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    used <= USED_W'(SLOTS));

  a_r6_slots_never_shrink: assert property (@(posedge clk) disable iff (!rst_n)
    used >= $past(used));

endmodule

bind dpot_core dpot_core_chk #(.DATA_W(DATA_W), .SLOTS(SLOTS)) u_chk (
  .clk(clk), .rst_n(rst_n), .wiper(wiper), .shutdown(shutdown),
  .perf_en(perf_en), .fire(fire), .hw_rise(hw_rise), .used(otp_used)
);

// File: tb/test_dpot_core.sv
module test_dpot_core;
  localparam int CLK_P = 10;
  localparam int HALF  = 5;
  localparam int NV    = 9;

  logic clk = 1'b0, rst_n = 1'b0, sclk = 1'b0, din = 1'b0, sync_n = 1'b1, hw_reset = 1'b0;
  logic sdo, shutdown, perf_en;
  logic [9:0] wiper;
  int errors = 0, checks = 0;
  logic [63:0] seen;

  always #(CLK_P/2) clk = ~clk;

  dpot_core i_dpot_core (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .din(din), .sync_n(sync_n),
    .hw_reset(hw_reset), .sdo(sdo), .wiper(wiper), .shutdown(shutdown),
    .perf_en(perf_en)
  );

  // {frame[15:0], wiper[9:0], shutdown, perf_en}
  localparam logic [27:0] VEC [0:NV-1] = '{
    {2'b00, 4'd1,  10'd100, 10'd512, 1'b0, 1'b0},
    {2'b00, 4'd6,  10'd2,   10'd512, 1'b0, 1'b0},
    {2'b00, 4'd1,  10'd100, 10'd100, 1'b0, 1'b0},
    {2'b00, 4'd13, 10'd1,   10'd100, 1'b0, 1'b0},
    {2'b00, 4'd8,  10'd1,   10'd100, 1'b1, 1'b0},
    {2'b00, 4'd1,  10'd200, 10'd200, 1'b1, 1'b0},
    {2'b00, 4'd8,  10'd0,   10'd200, 1'b0, 1'b0},
    {2'b00, 4'd6,  10'd6,   10'd200, 1'b0, 1'b1},
    {2'b00, 4'd4,  10'd0,   10'd512, 1'b0, 1'b0}
  };

  function automatic string vtag(input int i);
    case (i)
      0: return "R3";  1: return "R3";  2: return "R1";
      3: return "R10"; 4: return "R4";  5: return "R4";
      6: return "R4";  7: return "R3";  default: return "R5";
    endcase
  endfunction

  function automatic logic [15:0] fr(input int c, input int d);
    return {2'b00, 4'(c), 10'(d)};
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [63:0] bits, input int n, output logic [63:0] got);
    got = '0;
    @(negedge clk) sync_n = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int k = n-1; k >= 0; k--) begin
      din  = bits[k];
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      got[k] = sdo;
      sclk = 1'b0;
      repeat (HALF) @(negedge clk);
    end
    sync_n = 1'b1;
    repeat (10) @(negedge clk);
  endtask

  task automatic send(input logic [15:0] f);
    logic [63:0] g;
    xfer({48'd0, f}, 16, g);
  endtask

  task automatic readback(input logic [15:0] f, output logic [15:0] w);
    logic [63:0] g;
    send(f);
    xfer(64'd0, 16, g);
    w = g[15:0];
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] w;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R9 reset state
    check("R9 wiper", int'(wiper), 512);
    check("R9 shutdown", int'(shutdown), 0);
    check("R9 perf_en", int'(perf_en), 0);

    for (int i = 0; i < NV; i++) begin
      send(VEC[i][27:12]);
      check(vtag(i), int'(wiper), int'(VEC[i][11:2]));
      check(vtag(i), int'(shutdown), int'(VEC[i][1]));
      check(vtag(i), int'(perf_en), int'(VEC[i][0]));
    end

    // R7 wiper readback
    send(fr(6, 2));
    send(fr(1, 333));
    readback(fr(2, 0), w);
    check("R7 wiper readback", int'(w), 333);

    // R8 chaining, R1 last 16 bits execute
    xfer({32'd0, fr(1, 44), fr(1, 55)}, 32, seen);
    check("R1 last frame executes", int'(wiper), 55);
    check("R8 forwarded frame", int'(seen[15:0]), int'(fr(1, 44)));
    check("R8 previous contents", int'(seen[31:16]), 0);

    // R2 partial frames dropped
    xfer({54'd0, 10'h3FF}, 10, seen);
    check("R2 10-bit frame", int'(wiper), 55);
    xfer({47'd0, 1'b0, fr(1, 7)}, 17, seen);
    check("R2 17-bit frame", int'(wiper), 55);
    send(fr(1, 66));
    check("R1 recovers after partial", int'(wiper), 66);

    // R6 programming, R5 reload from slot
    send(fr(6, 3));
    send(fr(1, 300));
    send(fr(3, 0));
    send(fr(4, 0));
    check("R5 sw reset reload slot", int'(wiper), 300);
    send(fr(3, 0));
    readback(fr(5, 1), w);
    check("R6 program refused when disabled", int'(w), 0);
    readback(fr(5, 0), w);
    check("R7 slot readback", int'(w), 300);

    // R5 hardware reset
    send(fr(6, 6));
    send(fr(1, 55));
    check("R3 perf set", int'(perf_en), 1);
    @(negedge clk) hw_reset = 1'b1;
    repeat (6) @(negedge clk);
    hw_reset = 1'b0;
    repeat (4) @(negedge clk);
    check("R5 hw reset wiper", int'(wiper), 300);
    check("R5 hw reset perf", int'(perf_en), 0);
    send(fr(1, 9));
    check("R5 control defaults, write ignored", int'(wiper), 300);

    // R6 fill all slots
    send(fr(6, 3));
    for (int i = 1; i < 20; i++) begin
      send(fr(1, i * 10));
      send(fr(3, 0));
    end
    send(fr(1, 999));
    send(fr(3, 0));
    send(fr(4, 0));
    check("R6 full store refuses", int'(wiper), 190);
    readback(fr(5, 19), w);
    check("R6 last slot kept", int'(w), 190);
    readback(fr(5, 0), w);
    check("R6 first slot kept", int'(w), 300);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule